// File: doc/BRIEF.md
# Auxiliary-Channel Request Dispatcher with I2C Bridging

This block sits behind the receiver of a display auxiliary channel. It accepts one request at a time. Each request carries a 4-bit command code, an address and a byte count. Native commands walk a byte-addressed register space one location per step. I2C commands drive a simple master port that offers three operations: a start with address and direction, a single byte move that returns an acknowledge result, and a stop. Write bytes arrive on an input byte stream. Read bytes leave on an output byte stream. Each request finishes with a 2-bit reply code and a one-cycle done pulse.

Some I2C commands are marked as middle-of-transaction. For these the block keeps the I2C transaction open when the request ends. It also remembers the address and command code of the last such request. When a later middle-of-transaction request arrives while the bus is open, the block compares it with those remembered values. A match lets the bytes continue inside the same transaction. A mismatch makes the block close the bus with a stop and issue a fresh start. Plain I2C commands always open their own transaction and always close it at the end.

Top module: `aux_i2c_bridge`

## Requirements
- R1: Command codes are 0x0 = I2C write, 0x1 = I2C read, 0x4 = middle-of-transaction I2C write, 0x5 = middle-of-transaction I2C read, 0x8 = native write and 0x9 = native read. Any other code, and any length above MAX_LEN, gives reply NACK. Such a request causes no register or I2C operation and leaves the open/closed state of the I2C transaction unchanged.
- R2: A native request performs one register operation per byte. The first operation uses the request address, and the address increases by one after each successful byte. A native write takes each byte from the write stream. A native read delivers each byte on the read stream. If every byte succeeds, the reply is ACK.
- R3: In a native request, the first register operation that reports an error ends the request with reply NACK, and no further bytes follow. A native request of length zero replies NACK.
- R4: A plain I2C request first issues a stop if a transaction is open. It then issues a start carrying address bits [6:0] and the direction (read = 1 for codes 0x1 and 0x5). If the start is not acknowledged, the reply is I2C-NACK and no stop follows.
- R5: After a successful start, a plain I2C request moves its bytes and stops at the first unacknowledged byte. It always issues a stop at the end. The reply is ACK, or I2C-NACK if a byte failed.
- R6: A middle-of-transaction request issues a start only when no transaction is open. When a transaction is open with the same address and code, the bytes continue with no start. On success the transaction stays open and the reply is ACK, including for length zero.
- R7: If a middle-of-transaction request finds a transaction open but its address or its code differs from the last recorded one, the block issues a stop and then a new start.
- R8: In a middle-of-transaction request, an unacknowledged byte causes a stop, reply I2C-NACK and a closed transaction. An unacknowledged start gives reply I2C-NACK and leaves the transaction closed.
- R9: Reply codes are 00 = ACK, 01 = NACK and 10 = I2C-NACK. `rsp_done` is high for exactly one cycle per request. `req_ready` is high only while the block is idle.
- R10: After reset the block is idle with `req_ready` high, no port request raised, and no I2C transaction open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_cmd | input | 4 | Command code |
| req_addr | input | ADDR_W | Register address, or I2C address in bits [6:0] |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte pulse |
| rd_data | output | 8 | Read byte |
| rsp_done | output | 1 | One-cycle reply pulse |
| rsp_code | output | 2 | Reply code |
| reg_req | output | 1 | Register operation request, held until acknowledged |
| reg_we | output | 1 | Register write |
| reg_addr | output | ADDR_W | Register byte address |
| reg_wdata | output | 8 | Register write byte |
| reg_ack | input | 1 | Register operation complete |
| reg_err | input | 1 | Register operation failed, valid with reg_ack |
| reg_rdata | input | 8 | Register read byte, valid with reg_ack |
| i2c_req | output | 1 | I2C operation request, held until acknowledged |
| i2c_op | output | 2 | 0 = start, 1 = byte, 2 = stop |
| i2c_addr | output | I2C_AW | Target address for start |
| i2c_rnw | output | 1 | Direction for start and byte |
| i2c_wdata | output | 8 | Byte to send |
| i2c_ack | input | 1 | I2C operation complete |
| i2c_nack | input | 1 | Not acknowledged, valid with i2c_ack |
| i2c_rdata | input | 8 | Received byte, valid with i2c_ack |

## Verification
The bench builds the block with its defaults: a 20-bit register address, MAX_LEN of 16 and a 7-bit I2C address. A MAX_LEN of 16 makes the length field 5 bits wide, so an over-length count of 17 can be driven and its rejection tested. The register model faults on any address whose low byte is 0xEE, so one native request can succeed on some bytes and then fail part way. Because the vector table runs in one pass with no reset between vectors, the bus state carries over from one request to the next. This lets the bench reach every start, restart and stop decision, and check that a rejected request leaves an open transaction untouched.

// File: rtl/aux_bridge_pkg.sv
package aux_bridge_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        RSP_ACK      = 2'b00,
        RSP_NACK     = 2'b01,
        RSP_I2C_NACK = 2'b10
    } rsp_e;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_BYTE  = 2'd1,
        OP_STOP  = 2'd2
    } i2c_op_e;

    typedef enum logic [1:0] {
        K_BAD,
        K_NATIVE,
        K_PLAIN,
        K_MOT
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  rnw;
    } dec_t;

    localparam logic [CMD_W-1:0] C_I2C_WR  = 4'h0;
    localparam logic [CMD_W-1:0] C_I2C_RD  = 4'h1;
    localparam logic [CMD_W-1:0] C_MOT_WR  = 4'h4;
    localparam logic [CMD_W-1:0] C_MOT_RD  = 4'h5;
    localparam logic [CMD_W-1:0] C_NAT_WR  = 4'h8;
    localparam logic [CMD_W-1:0] C_NAT_RD  = 4'h9;

    function automatic dec_t decode_cmd(input logic [CMD_W-1:0] c);
        dec_t d;
        unique case (c)
            C_I2C_WR: d = '{kind: K_PLAIN,  rnw: 1'b0};
            C_I2C_RD: d = '{kind: K_PLAIN,  rnw: 1'b1};
            C_MOT_WR: d = '{kind: K_MOT,    rnw: 1'b0};
            C_MOT_RD: d = '{kind: K_MOT,    rnw: 1'b1};
            C_NAT_WR: d = '{kind: K_NATIVE, rnw: 1'b0};
            C_NAT_RD: d = '{kind: K_NATIVE, rnw: 1'b1};
            default:  d = '{kind: K_BAD,    rnw: 1'b1};
        endcase
        return d;
    endfunction

endpackage

// File: rtl/aux_cmd_decode.sv
module aux_cmd_decode
    import aux_bridge_pkg::*;
#(
    parameter int MAX_LEN = 16,
    parameter int LEN_W   = 5
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic [LEN_W-1:0] len,
    output dec_t             dec
);
    always_comb begin
        dec = decode_cmd(cmd);
        // over-length requests are rejected like unknown codes
        if (len > LEN_W'(MAX_LEN)) begin
            dec.kind = K_BAD;
            dec.rnw  = 1'b1;
        end
    end
endmodule

// File: rtl/aux_mot_tracker.sv
module aux_mot_tracker
    import aux_bridge_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_open,
    input  logic              clr_open,
    input  logic              record,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [CMD_W-1:0]  cur_cmd,
    output logic              bus_open,
    output logic              mismatch
);
    logic [ADDR_W-1:0] last_addr;
    logic [CMD_W-1:0]  last_cmd;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_open  <= 1'b0;
            last_addr <= '0;
            last_cmd  <= '0;
        end else begin
            if (set_open)
                bus_open <= 1'b1;
            else if (clr_open)
                bus_open <= 1'b0;
            if (record) begin
                last_addr <= cur_addr;
                last_cmd  <= cur_cmd;
            end
        end
    end

    assign mismatch = (cur_addr != last_addr) || (cur_cmd != last_cmd);

    // R8
    open_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(set_open && clr_open));
    // R6
    open_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_open) |-> $past(set_open));
    // R8
    stop_closes_chk: assert property (@(posedge clk) disable iff (rst)
        clr_open |=> !bus_open);
endmodule

// File: rtl/aux_seq_fsm.sv
module aux_seq_fsm
    import aux_bridge_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int LEN_W  = 5,
    parameter int I2C_AW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  dec_t              dec,
    output logic [CMD_W-1:0]  lat_cmd,
    output logic [ADDR_W-1:0] lat_addr,
    output logic [LEN_W-1:0]  lat_len,
    input  logic              bus_open,
    input  logic              mismatch,
    output logic              set_open,
    output logic              clr_open,
    output logic              record,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rsp_done,
    output logic [1:0]        rsp_code,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic              reg_ack,
    input  logic              reg_err,
    input  logic [7:0]        reg_rdata,
    output logic              i2c_req,
    output logic [1:0]        i2c_op,
    output logic [I2C_AW-1:0] i2c_addr,
    output logic              i2c_rnw,
    output logic [7:0]        i2c_wdata,
    input  logic              i2c_ack,
    input  logic              i2c_nack,
    input  logic [7:0]        i2c_rdata
);
    typedef enum logic [3:0] {
        S_IDLE, S_DISPATCH, S_PRESTOP, S_START, S_NEXT,
        S_FETCH, S_NOP, S_IOP, S_POSTSTOP, S_REPLY
    } state_e;

    state_e            state;
    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  rem_q;
    logic [7:0]        wbyte_q;
    rsp_e              code_q;
    logic              rd_valid_q;
    logic [7:0]        rd_data_q;
    logic              is_native;

    assign is_native = (dec.kind == K_NATIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            cmd_q      <= '0;
            addr_q     <= '0;
            rem_q      <= '0;
            wbyte_q    <= '0;
            code_q     <= RSP_ACK;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= 1'b0;
            case (state)
                S_IDLE: if (req_valid) begin
                    cmd_q  <= req_cmd;
                    addr_q <= req_addr;
                    rem_q  <= req_len;
                    state  <= S_DISPATCH;
                end
                S_DISPATCH: begin
                    code_q <= RSP_ACK;
                    case (dec.kind)
                        K_BAD: begin
                            code_q <= RSP_NACK;
                            state  <= S_REPLY;
                        end
                        K_NATIVE: begin
                            if (rem_q == '0) begin
                                code_q <= RSP_NACK;
                                state  <= S_REPLY;
                            end else begin
                                state <= S_NEXT;
                            end
                        end
                        K_PLAIN: state <= bus_open ? S_PRESTOP : S_START;
                        default: begin
                            if (!bus_open)
                                state <= S_START;
                            else if (mismatch)
                                state <= S_PRESTOP;
                            else
                                state <= S_NEXT;
                        end
                    endcase
                end
                S_PRESTOP: if (i2c_ack) state <= S_START;
                S_START: if (i2c_ack) begin
                    if (i2c_nack) begin
                        code_q <= RSP_I2C_NACK;
                        state  <= S_REPLY;
                    end else begin
                        state <= S_NEXT;
                    end
                end
                S_NEXT: begin
                    if (rem_q == '0)
                        state <= (dec.kind == K_PLAIN) ? S_POSTSTOP : S_REPLY;
                    else if (!dec.rnw)
                        state <= S_FETCH;
                    else
                        state <= is_native ? S_NOP : S_IOP;
                end
                S_FETCH: if (wr_valid) begin
                    wbyte_q <= wr_data;
                    state   <= is_native ? S_NOP : S_IOP;
                end
                S_NOP: if (reg_ack) begin
                    if (reg_err) begin
                        code_q <= RSP_NACK;
                        state  <= S_REPLY;
                    end else begin
                        rd_valid_q <= dec.rnw;
                        rd_data_q  <= reg_rdata;
                        addr_q     <= addr_q + ADDR_W'(1);
                        rem_q      <= rem_q - LEN_W'(1);
                        state      <= S_NEXT;
                    end
                end
                S_IOP: if (i2c_ack) begin
                    if (i2c_nack) begin
                        code_q <= RSP_I2C_NACK;
                        state  <= S_POSTSTOP;
                    end else begin
                        rd_valid_q <= dec.rnw;
                        rd_data_q  <= i2c_rdata;
                        rem_q      <= rem_q - LEN_W'(1);
                        state      <= S_NEXT;
                    end
                end
                S_POSTSTOP: if (i2c_ack) state <= S_REPLY;
                S_REPLY:    state <= S_IDLE;
                default:    state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        i2c_req = 1'b0;
        i2c_op  = OP_BYTE;
        unique case (state)
            S_PRESTOP, S_POSTSTOP: begin i2c_req = 1'b1; i2c_op = OP_STOP;  end
            S_START:               begin i2c_req = 1'b1; i2c_op = OP_START; end
            S_IOP:                 begin i2c_req = 1'b1; i2c_op = OP_BYTE;  end
            default: ;
        endcase
    end

    assign set_open  = (state == S_START) && i2c_ack && !i2c_nack;
    assign record    = set_open && (dec.kind == K_MOT);
    assign clr_open  = ((state == S_PRESTOP) || (state == S_POSTSTOP)) && i2c_ack;
    assign i2c_addr  = addr_q[I2C_AW-1:0];
    assign i2c_rnw   = dec.rnw;
    assign i2c_wdata = wbyte_q;
    assign reg_req   = (state == S_NOP);
    assign reg_we    = !dec.rnw;
    assign reg_addr  = addr_q;
    assign reg_wdata = wbyte_q;
    assign wr_ready  = (state == S_FETCH);
    assign req_ready = (state == S_IDLE);
    assign rsp_done  = (state == S_REPLY);
    assign rsp_code  = code_q;
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;
    assign lat_cmd   = cmd_q;
    assign lat_addr  = addr_q;
    assign lat_len   = rem_q;

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);
    // R4
    i2c_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (i2c_req && !i2c_ack) |=> (i2c_req && $stable(i2c_op)));
    // R2
    reg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr)));
    // R1
    port_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(i2c_req && reg_req));
endmodule

// File: rtl/aux_i2c_bridge.sv
module aux_i2c_bridge
    import aux_bridge_pkg::*;
#(
    parameter  int ADDR_W  = 20,
    parameter  int MAX_LEN = 16,
    parameter  int I2C_AW  = 7,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wr_valid,
    output logic              wr_ready,
    input  logic [7:0]        wr_data,
    output logic              rd_valid,
    output logic [7:0]        rd_data,
    output logic              rsp_done,
    output logic [1:0]        rsp_code,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic              reg_ack,
    input  logic              reg_err,
    input  logic [7:0]        reg_rdata,
    output logic              i2c_req,
    output logic [1:0]        i2c_op,
    output logic [I2C_AW-1:0] i2c_addr,
    output logic              i2c_rnw,
    output logic [7:0]        i2c_wdata,
    input  logic              i2c_ack,
    input  logic              i2c_nack,
    input  logic [7:0]        i2c_rdata
);
    dec_t              dec;
    logic [CMD_W-1:0]  lat_cmd;
    logic [ADDR_W-1:0] lat_addr;
    logic [LEN_W-1:0]  lat_len;
    logic              bus_open, mismatch, set_open, clr_open, record;

    aux_cmd_decode #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_dec (
        .cmd(lat_cmd), .len(lat_len), .dec(dec)
    );

    aux_mot_tracker #(.ADDR_W(ADDR_W)) u_trk (
        .clk(clk), .rst(rst), .set_open(set_open), .clr_open(clr_open),
        .record(record), .cur_addr(lat_addr), .cur_cmd(lat_cmd),
        .bus_open(bus_open), .mismatch(mismatch)
    );

    aux_seq_fsm #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .I2C_AW(I2C_AW)) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .dec(dec),
        .lat_cmd(lat_cmd), .lat_addr(lat_addr), .lat_len(lat_len),
        .bus_open(bus_open), .mismatch(mismatch),
        .set_open(set_open), .clr_open(clr_open), .record(record),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rsp_done(rsp_done), .rsp_code(rsp_code),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
        .reg_rdata(reg_rdata),
        .i2c_req(i2c_req), .i2c_op(i2c_op), .i2c_addr(i2c_addr),
        .i2c_rnw(i2c_rnw), .i2c_wdata(i2c_wdata), .i2c_ack(i2c_ack),
        .i2c_nack(i2c_nack), .i2c_rdata(i2c_rdata)
    );
endmodule

// File: tb/test_aux_i2c_bridge.sv
module test_aux_i2c_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 20;
    localparam int LEN_W  = 5;

    logic clk, rst;
    logic req_valid, req_ready;
    logic [3:0] req_cmd;
    logic [ADDR_W-1:0] req_addr;
    logic [LEN_W-1:0] req_len;
    logic wr_valid, wr_ready;
    logic [7:0] wr_data;
    logic rd_valid;
    logic [7:0] rd_data;
    logic rsp_done;
    logic [1:0] rsp_code;
    logic reg_req, reg_we, reg_ack, reg_err;
    logic [ADDR_W-1:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic i2c_req, i2c_rnw, i2c_ack, i2c_nack;
    logic [1:0] i2c_op;
    logic [6:0] i2c_addr;
    logic [7:0] i2c_wdata, i2c_rdata;

    aux_i2c_bridge i_aux_i2c_bridge (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .rsp_done(rsp_done), .rsp_code(rsp_code),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
        .reg_rdata(reg_rdata),
        .i2c_req(i2c_req), .i2c_op(i2c_op), .i2c_addr(i2c_addr),
        .i2c_rnw(i2c_rnw), .i2c_wdata(i2c_wdata), .i2c_ack(i2c_ack),
        .i2c_nack(i2c_nack), .i2c_rdata(i2c_rdata)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural slaves, operation counters
    logic       clr_cnt;
    logic       inj_start_nack;
    int         inj_byte_nack;
    int         start_cnt, stop_cnt, ibyte_cnt, reg_cnt, byte_idx, rd_n;
    logic [6:0] last_start_addr;
    logic       last_start_rnw;
    logic [7:0] last_i2c_wdata;
    logic [7:0] rd_buf [16];
    logic [7:0] mem [256];

    always @(posedge clk) begin
        if (rst) begin
            i2c_ack <= 1'b0; i2c_nack <= 1'b0; i2c_rdata <= '0;
            reg_ack <= 1'b0; reg_err <= 1'b0; reg_rdata <= '0;
            wr_data <= 8'h31;
        end else begin
            i2c_ack <= i2c_req && !i2c_ack;
            if (i2c_req && !i2c_ack) begin
                i2c_nack  <= (i2c_op == 2'd0) ? inj_start_nack :
                             (i2c_op == 2'd1) ? (byte_idx == inj_byte_nack) : 1'b0;
                i2c_rdata <= 8'hA0 + 8'(byte_idx);
            end
            reg_ack <= reg_req && !reg_ack;
            if (reg_req && !reg_ack) begin
                reg_err   <= (reg_addr[7:0] == 8'hEE);
                reg_rdata <= mem[reg_addr[7:0]];
            end
            if (reg_req && reg_ack && reg_we && !reg_err)
                mem[reg_addr[7:0]] <= reg_wdata;
            if (wr_valid && wr_ready)
                wr_data <= wr_data + 8'd7;
        end
        if (clr_cnt) begin
            start_cnt <= 0; stop_cnt <= 0; ibyte_cnt <= 0;
            reg_cnt <= 0; byte_idx <= 0; rd_n <= 0;
        end else begin
            if (i2c_req && i2c_ack) begin
                case (i2c_op)
                    2'd0: begin
                        start_cnt <= start_cnt + 1;
                        last_start_addr <= i2c_addr;
                        last_start_rnw  <= i2c_rnw;
                    end
                    2'd1: begin
                        ibyte_cnt <= ibyte_cnt + 1;
                        byte_idx  <= byte_idx + 1;
                        last_i2c_wdata <= i2c_wdata;
                    end
                    default: stop_cnt <= stop_cnt + 1;
                endcase
            end
            if (reg_req && reg_ack) reg_cnt <= reg_cnt + 1;
            if (rd_valid) begin
                rd_buf[rd_n[3:0]] <= rd_data;
                rd_n <= rd_n + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 40000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] c, input logic [19:0] a, input logic [4:0] l,
                       input logic sn, input int bn,
                       output logic [1:0] code, output logic pulse_ok);
        @(negedge clk);
        inj_start_nack = sn; inj_byte_nack = bn; clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
        req_cmd = c; req_addr = a; req_len = l; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_done) @(negedge clk);
        code = rsp_code;
        @(negedge clk);
        pulse_ok = !rsp_done;
    endtask

    typedef struct packed {
        logic [3:0]  rq;
        logic [3:0]  cmd;
        logic [19:0] addr;
        logic [4:0]  len;
        logic        sn;
        logic [4:0]  bn;
        logic [1:0]  code;
        logic [1:0]  st;
        logic [1:0]  sp;
        logic [4:0]  ib;
        logic [4:0]  rg;
    } vec_t;

    localparam int NV = 22;
    // rq: requirement number printed with each miscompare
    localparam vec_t VECS [NV] = '{
        '{4'd2,  4'h8, 20'h00010, 5'd4,  1'b0, 5'd31, 2'd0, 2'd0, 2'd0, 5'd0, 5'd4}, // R2 native write
        '{4'd2,  4'h9, 20'h00010, 5'd4,  1'b0, 5'd31, 2'd0, 2'd0, 2'd0, 5'd0, 5'd4}, // R2 native read
        '{4'd3,  4'h8, 20'h000EC, 5'd4,  1'b0, 5'd31, 2'd1, 2'd0, 2'd0, 5'd0, 5'd3}, // R3 fault on third byte
        '{4'd3,  4'h9, 20'h00020, 5'd0,  1'b0, 5'd31, 2'd1, 2'd0, 2'd0, 5'd0, 5'd0}, // R3 zero length
        '{4'd1,  4'h3, 20'h00050, 5'd2,  1'b0, 5'd31, 2'd1, 2'd0, 2'd0, 5'd0, 5'd0}, // R1 unknown code
        '{4'd5,  4'h0, 20'h00050, 5'd3,  1'b0, 5'd31, 2'd0, 2'd1, 2'd1, 5'd3, 5'd0}, // R5 plain write
        '{4'd4,  4'h1, 20'h00050, 5'd2,  1'b1, 5'd31, 2'd2, 2'd1, 2'd0, 5'd0, 5'd0}, // R4 start refused
        '{4'd5,  4'h0, 20'h00050, 5'd4,  1'b0, 5'd1,  2'd2, 2'd1, 2'd1, 5'd2, 5'd0}, // R5 byte refused
        '{4'd6,  4'h4, 20'h00050, 5'd2,  1'b0, 5'd31, 2'd0, 2'd1, 2'd0, 5'd2, 5'd0}, // R6 open
        '{4'd6,  4'h4, 20'h00050, 5'd1,  1'b0, 5'd31, 2'd0, 2'd0, 2'd0, 5'd1, 5'd0}, // R6 continue
        '{4'd7,  4'h5, 20'h00050, 5'd2,  1'b0, 5'd31, 2'd0, 2'd1, 2'd1, 5'd2, 5'd0}, // R7 code change
        '{4'd7,  4'h5, 20'h00051, 5'd1,  1'b0, 5'd31, 2'd0, 2'd1, 2'd1, 5'd1, 5'd0}, // R7 address change
        '{4'd1,  4'hF, 20'h00051, 5'd1,  1'b0, 5'd31, 2'd1, 2'd0, 2'd0, 5'd0, 5'd0}, // R1 unknown while open
        '{4'd6,  4'h5, 20'h00051, 5'd0,  1'b0, 5'd31, 2'd0, 2'd0, 2'd0, 5'd0, 5'd0}, // R6 zero length, still open
        '{4'd4,  4'h0, 20'h00022, 5'd1,  1'b0, 5'd31, 2'd0, 2'd1, 2'd2, 5'd1, 5'd0}, // R4 plain closes open bus
        '{4'd8,  4'h4, 20'h00022, 5'd3,  1'b0, 5'd2,  2'd2, 2'd1, 2'd1, 5'd3, 5'd0}, // R8 byte refused
        '{4'd8,  4'h4, 20'h00022, 5'd1,  1'b0, 5'd31, 2'd0, 2'd1, 2'd0, 5'd1, 5'd0}, // R8 closed after failure
        '{4'd8,  4'h4, 20'h00030, 5'd1,  1'b1, 5'd31, 2'd2, 2'd1, 2'd1, 5'd0, 5'd0}, // R8 restart refused
        '{4'd8,  4'h4, 20'h00022, 5'd1,  1'b0, 5'd31, 2'd0, 2'd1, 2'd0, 5'd1, 5'd0}, // R8 closed after refused start
        '{4'd1,  4'h8, 20'h00000, 5'd17, 1'b0, 5'd31, 2'd1, 2'd0, 2'd0, 5'd0, 5'd0}, // R1 over-length
        '{4'd1,  4'h4, 20'h00022, 5'd1,  1'b0, 5'd31, 2'd0, 2'd0, 2'd0, 5'd1, 5'd0}, // R1 bus still open after rejection
        '{4'd5,  4'h1, 20'h00022, 5'd0,  1'b0, 5'd31, 2'd0, 2'd1, 2'd2, 5'd0, 5'd0}  // R5 stop even with no bytes
    };

    initial begin
        logic [1:0] code;
        logic       pok;
        logic [7:0] w0;
        string      tg;
        rst = 1'b1; req_valid = 1'b0; req_cmd = '0; req_addr = '0; req_len = '0;
        wr_valid = 1'b1; clr_cnt = 1'b1; inj_start_nack = 1'b0; inj_byte_nack = 31;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10", "req_ready", int'(req_ready), 1);
        check("R10", "i2c_req", int'(i2c_req), 0);
        check("R10", "reg_req", int'(reg_req), 0);
        check("R10", "rsp_done", int'(rsp_done), 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i].cmd, VECS[i].addr, VECS[i].len, VECS[i].sn, int'(VECS[i].bn), code, pok);
            tg = $sformatf("R%0d vec%0d", VECS[i].rq, i);
            check(tg, "reply", int'(code), int'(VECS[i].code));
            check(tg, "starts", start_cnt, int'(VECS[i].st));
            check(tg, "stops", stop_cnt, int'(VECS[i].sp));
            check(tg, "i2c bytes", ibyte_cnt, int'(VECS[i].ib));
            check(tg, "reg ops", reg_cnt, int'(VECS[i].rg));
            // R9 single-cycle done pulse
            check("R9", "done pulse width", int'(pok), 1);
        end

        // R2 native write then read back with incrementing addresses
        @(negedge clk);
        w0 = wr_data;
        run(4'h8, 20'h00140, 5'd3, 1'b0, 31, code, pok);
        check("R2", "write reply", int'(code), 0);
        run(4'h9, 20'h00140, 5'd3, 1'b0, 31, code, pok);
        check("R2", "read reply", int'(code), 0);
        check("R2", "read count", rd_n, 3);
        for (int k = 0; k < 3; k++)
            check("R2", "read byte", int'(rd_buf[k]), int'(8'(w0 + 8'(7 * k))));

        // R3 read faulting part way delivers only earlier bytes
        run(4'h9, 20'h000EC, 5'd4, 1'b0, 31, code, pok);
        check("R3", "reply", int'(code), 1);
        check("R3", "bytes delivered", rd_n, 2);

        // R4 start carries address and direction; read bytes forwarded
        run(4'h1, 20'hFFF2A, 5'd2, 1'b0, 31, code, pok);
        check("R4", "start addr", int'(last_start_addr), 32'h2A);
        check("R4", "start dir", int'(last_start_rnw), 1);
        check("R4", "rd byte0", int'(rd_buf[0]), 32'hA0);
        check("R4", "rd byte1", int'(rd_buf[1]), 32'hA1);

        // R6 write byte sent from the stream, bus left open
        @(negedge clk);
        w0 = wr_data;
        run(4'h4, 20'h00033, 5'd1, 1'b0, 31, code, pok);
        check("R6", "reply", int'(code), 0);
        check("R6", "sent byte", int'(last_i2c_wdata), int'(w0));
        check("R6", "start dir", int'(last_start_rnw), 0);

        // R10 reset closes the open transaction
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        run(4'h4, 20'h00033, 5'd1, 1'b0, 31, code, pok);
        check("R10", "start after reset", start_cnt, 1);
        check("R10", "no stop after reset", stop_cnt, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule